// File: doc/BRIEF.md
# Pipelined Bus Cycle Controller

This block sequences external memory and I/O cycles on the processor side. Every bus state lasts one clock. A cycle starts with an address state, in which the strobe `ads_no` is low and the captured address and cycle type are on `addr_o`/`def_o`. One or more data states follow. The data phase ends when `ready_ni` is sampled low. Internal logic offers a cycle by holding `req_i` together with its address and type. The block takes the cycle with a one-clock pulse on `req_ack_o` and reports the end of each cycle on `cyc_done_o`.

The system can ask for the next address early by pulling `na_ni` low. The block then puts the next pending address and its strobe on the bus while the current cycle is still waiting for `ready_ni`. Back-to-back cycles can then overlap their address and data phases. The choice is made anew for every cycle, and `na_ni` is only looked at once the current address has been on the bus for a full state. An external master can take the bus with `hold_i`. The block grants it with `hlda_o` at a cycle boundary.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: While `rst_ni` is low, `ads_no` is high and `hlda_o` is low. After reset the controller sits idle with no address outstanding and `addr_o`/`def_o` at zero.
- R2: `req_ack_o` is high in the cycle in which `req_i` is accepted. In the next cycle `ads_no` is low and `addr_o`/`def_o` equal the `req_addr_i`/`req_def_i` of the accepting cycle. From idle or hold, an accepted request takes one address state and then a data state.
- R3: In a data state with `ready_ni` high (not ready) and `na_ni` high, the controller inserts a wait state. It gives no `cyc_done_o`, no strobe and no acknowledge.
- R4: `ready_ni` low in any data state gives `cyc_done_o` in that cycle. After a non-pipelined data state, the next state is hold if `hold_i` is high. Otherwise it is a new address state with `req_ack_o` in the same cycle if `req_i` is high, and idle if not.
- R5: `na_ni` has no effect in an address state entered from idle or hold. It also has no effect in a data state where `ready_ni` is low in the same cycle. Such cycles stay non-pipelined.
- R6: `na_ni` low in a non-ready, non-pipelined data state, with `req_i` high and `hold_i` low, gives `req_ack_o` in that cycle. `ads_no` goes low in the next cycle with the new address, and the current cycle is still outstanding.
- R7: `na_ni` accepted with no request pending, or with `hold_i` high, issues nothing. If `req_i` then rises, with `hold_i` low, before ready, the request is issued pipelined at once. If ready comes first, the cycle ends as in R4.
- R8: In the state where a pipelined address is on the bus, and in its wait form, `ready_ni` low with `na_ni` low, `req_i` high and `hold_i` low issues another address in the next cycle. Otherwise the next state is a plain data state without strobe, which waits for its own ready.
- R9: In the wait form of a pipelined state, `na_ni` is ignored while not ready. There is no strobe and no acknowledge.
- R10: `hlda_o` is high only in the hold state. Hold is entered from idle or at a cycle end when `hold_i` is high, and hold wins over `req_i`. The block stays in hold while `hold_i` is high. It leaves to an address state (with acknowledge) if `req_i` is high, and to idle if not.
- R11: `addr_o` and `def_o` change only in cycles in which `ads_no` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one bus state per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Internal cycle request, held until acknowledged |
| req_addr_i | input | AW | Address of the requested cycle |
| req_def_i | input | DW | Cycle type of the requested cycle |
| req_ack_o | output | 1 | Request taken; address goes out next cycle |
| cyc_done_o | output | 1 | Current cycle ends this clock |
| ready_ni | input | 1 | Cycle acknowledge, active low |
| na_ni | input | 1 | Next-address request, active low |
| hold_i | input | 1 | Bus request from another master |
| ads_no | output | 1 | Address strobe, active low |
| addr_o | output | AW | Bus address |
| def_o | output | DW | Bus cycle type |
| hlda_o | output | 1 | Hold acknowledge |

## Verification
The checker watches the following on every cycle:
- the strobe follows each acknowledge with the captured address;
- the address is stable outside strobe cycles;
- no completion is reported while not ready;
- hold acknowledge never overlaps a strobe or a completion;
- hold acknowledge begins only after a request for the bus and drops once that request goes away.

The choice between pipelined and non-pipelined sequencing depends on the history of `na_ni` within a cycle. That choice is shown only by the bench's directed and random runs against its state model. The same holds for the rules that ignore `na_ni` after idle and during pipelined waits, and for the priority of hold over pending requests.

// File: rtl/bus_cyc_pkg.sv
package bus_cyc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ADDR    = 3'd1,
    ST_DATA    = 3'd2,
    ST_DATA_NA = 3'd3,
    ST_PADDR   = 3'd4,
    ST_PWAIT   = 3'd5,
    ST_HOLD    = 3'd6
  } bus_st_e;
endpackage

// File: rtl/bus_seq_fsm.sv
module bus_seq_fsm
  import bus_cyc_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_i,
  input  logic    rdy_i,
  input  logic    na_i,
  input  logic    hold_i,
  output bus_st_e st_o,
  output logic    issue_o,
  output logic    done_o
);
  bus_st_e st_q, st_d;
  logic    go_req;

  assign go_req = req_i && !hold_i;

  always_comb begin
    st_d    = st_q;
    issue_o = 1'b0;
    done_o  = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_HOLD: begin
        if (hold_i) st_d = ST_HOLD;
        else if (req_i) begin
          st_d    = ST_ADDR;
          issue_o = 1'b1;
        end else st_d = ST_IDLE;
      end
      ST_ADDR: st_d = ST_DATA;
      ST_DATA, ST_DATA_NA: begin
        if (rdy_i) begin
          done_o = 1'b1;
          if (hold_i) st_d = ST_HOLD;
          else if (req_i) begin
            st_d    = ST_ADDR;
            issue_o = 1'b1;
          end else st_d = ST_IDLE;
        end else if (st_q == ST_DATA_NA || na_i) begin
          // next address granted: issue now or remember the grant
          if (go_req) begin
            st_d    = ST_PADDR;
            issue_o = 1'b1;
          end else st_d = ST_DATA_NA;
        end
      end
      ST_PADDR, ST_PWAIT: begin
        if (rdy_i) begin
          done_o = 1'b1;
          if (na_i && go_req) begin
            st_d    = ST_PADDR;
            issue_o = 1'b1;
          end else st_d = ST_DATA;
        end else st_d = ST_PWAIT;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign st_o = st_q;
endmodule

// File: rtl/bus_addr_reg.sv
module bus_addr_reg #(
  parameter int W = 27
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= d_i;
  end
endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
  import bus_cyc_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_def_i,
  output logic          req_ack_o,
  output logic          cyc_done_o,
  input  logic          ready_ni,
  input  logic          na_ni,
  input  logic          hold_i,
  output logic          ads_no,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] def_o,
  output logic          hlda_o
);
  localparam int LW = AW + DW;

  bus_st_e       st;
  logic          issue;
  logic [LW-1:0] lat_q;

  bus_seq_fsm u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .rdy_i  (!ready_ni),
    .na_i   (!na_ni),
    .hold_i (hold_i),
    .st_o   (st),
    .issue_o(issue),
    .done_o (cyc_done_o)
  );

  bus_addr_reg #(.W(LW)) u_lat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ld_i  (issue),
    .d_i   ({req_def_i, req_addr_i}),
    .q_o   (lat_q)
  );

  assign req_ack_o = issue;
  assign ads_no    = !(st == ST_ADDR || st == ST_PADDR);
  assign hlda_o    = (st == ST_HOLD);
  assign addr_o    = lat_q[AW-1:0];
  assign def_o     = lat_q[LW-1:AW];
endmodule

// File: rtl/bus_cyc_chk.sv
module bus_cyc_chk #(
  parameter int AW = 24,
  parameter int DW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_ack_o,
  input logic          cyc_done_o,
  input logic          ready_ni,
  input logic          hold_i,
  input logic          ads_no,
  input logic          hlda_o,
  input logic [AW-1:0] req_addr_i,
  input logic [DW-1:0] req_def_i,
  input logic [AW-1:0] addr_o,
  input logic [DW-1:0] def_o
);
  assert_reset_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (ads_no && !hlda_o));

  assert_issue_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ack_o |=> (!ads_no && addr_o == $past(req_addr_i) && def_o == $past(req_def_i)));

  assert_wait_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_ni |-> !cyc_done_o);

  assert_hlda_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hlda_o |-> (ads_no && !cyc_done_o));

  assert_hlda_rel_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hlda_o && !hold_i) |=> !hlda_o);

  assert_hlda_entry_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hlda_o) |-> $past(hold_i));

  assert_addr_stable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ads_no |-> ($stable(addr_o) && $stable(def_o)));
endmodule

bind bus_cycle_ctrl bus_cyc_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_ack_o (req_ack_o),
  .cyc_done_o(cyc_done_o),
  .ready_ni  (ready_ni),
  .hold_i    (hold_i),
  .ads_no    (ads_no),
  .hlda_o    (hlda_o),
  .req_addr_i(req_addr_i),
  .req_def_i (req_def_i),
  .addr_o    (addr_o),
  .def_o     (def_o)
);

// File: tb/bus_cycle_ctrl_tb.sv
`timescale 1ns/1ps
module bus_cycle_ctrl_tb;
  localparam int AW = 24;
  localparam int DW = 3;
  localparam int M_IDLE = 0, M_ADDR = 1, M_DATA = 2, M_DNA = 3, M_PADDR = 4, M_PWAIT = 5, M_HOLD = 6;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_i = 1'b0, ready_ni = 1'b1, na_ni = 1'b1, hold_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [DW-1:0] req_def_i = '0;
  logic req_ack_o, cyc_done_o, ads_no, hlda_o;
  logic [AW-1:0] addr_o;
  logic [DW-1:0] def_o;

  int n_chk = 0, n_fail = 0;
  int ms = M_IDLE;
  bit fin = 0, last_ack = 0;
  logic [AW-1:0] lat_a = '0, pend_a = 24'h12_3456;
  logic [DW-1:0] lat_d = '0, pend_d = 3'd5;

  always #5 clk = ~clk;

  bus_cycle_ctrl #(.AW(AW), .DW(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .req_addr_i(req_addr_i),
    .req_def_i(req_def_i), .req_ack_o(req_ack_o), .cyc_done_o(cyc_done_o),
    .ready_ni(ready_ni), .na_ni(na_ni), .hold_i(hold_i), .ads_no(ads_no),
    .addr_o(addr_o), .def_o(def_o), .hlda_o(hlda_o)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  // reference state model built from the requirements
  function automatic void mstep(input int s, input bit r, input bit n, input bit q, input bit h,
                                output int ns, output bit ack, output bit dn);
    ns = s; ack = 0; dn = 0;
    case (s)
      M_IDLE, M_HOLD: begin
        if (h) ns = M_HOLD;
        else if (q) begin ns = M_ADDR; ack = 1; end
        else ns = M_IDLE;
      end
      M_ADDR: ns = M_DATA;
      M_DATA, M_DNA: begin
        if (r) begin
          dn = 1;
          if (h) ns = M_HOLD;
          else if (q) begin ns = M_ADDR; ack = 1; end
          else ns = M_IDLE;
        end else if (s == M_DNA || n) begin
          if (q && !h) begin ns = M_PADDR; ack = 1; end
          else ns = M_DNA;
        end
      end
      default: begin
        if (r) begin
          dn = 1;
          if (n && q && !h) begin ns = M_PADDR; ack = 1; end
          else ns = M_DATA;
        end else ns = M_PWAIT;
      end
    endcase
  endfunction

  task automatic step(input bit r, input bit n, input bit q, input bit h, input string tag);
    int ns;
    bit ack, dn;
    @(negedge clk);
    ready_ni = !r; na_ni = !n; req_i = q; hold_i = h;
    req_addr_i = pend_a; req_def_i = pend_d;
    #1;
    mstep(ms, r, n, q, h, ns, ack, dn);
    chk(tag, "ads_no", 32'(ads_no), 32'(!(ms == M_ADDR || ms == M_PADDR)));
    chk(tag, "hlda_o", 32'(hlda_o), 32'(ms == M_HOLD));
    chk(tag, "cyc_done_o", 32'(cyc_done_o), 32'(dn));
    chk(tag, "req_ack_o", 32'(req_ack_o), 32'(ack));
    chk(tag, "addr_o", 32'(addr_o), 32'(lat_a));
    chk(tag, "def_o", 32'(def_o), 32'(lat_d));
    if (ack) begin
      lat_a = pend_a; lat_d = pend_d;
      pend_a = 24'($urandom); pend_d = 3'($urandom);
    end
    last_ack = ack;
    ms = ns;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit q_on;
    void'($urandom(32'h5eed_0b05));
    // R1: reset state
    repeat (2) @(negedge clk);
    chk("R1", "ads_no", 32'(ads_no), 32'd1);
    chk("R1", "hlda_o", 32'(hlda_o), 32'd0);
    chk("R1", "addr_o", 32'(addr_o), 32'd0);
    rst_ni = 1'b1;
    step(0, 0, 0, 0, "R1");

    // R2 R5 R3 R4: non-pipelined flow, NA ignored after idle and under ready
    step(0, 1, 1, 0, "R2");
    step(0, 1, 0, 0, "R5");
    step(0, 0, 0, 0, "R3");
    step(0, 0, 0, 0, "R3");
    step(1, 1, 1, 0, "R5");
    step(0, 0, 0, 0, "R2");
    step(1, 0, 0, 0, "R4");
    step(0, 0, 0, 0, "R4");

    // R6 R8 R9: enter and leave pipelining
    step(0, 0, 1, 0, "R2");
    step(0, 0, 1, 0, "R2");
    step(0, 1, 1, 0, "R6");
    step(1, 1, 1, 0, "R8");
    step(0, 0, 1, 0, "R8");
    step(0, 1, 1, 0, "R9");
    step(0, 1, 1, 0, "R9");
    step(1, 0, 1, 0, "R8");
    step(1, 0, 1, 0, "R4");
    step(1, 0, 0, 0, "R2");
    step(1, 0, 0, 0, "R4");

    // R7: NA granted with no request pending
    step(0, 0, 1, 0, "R2");
    step(0, 0, 0, 0, "R7");
    step(0, 1, 0, 0, "R7");
    step(0, 0, 0, 0, "R7");
    step(0, 0, 1, 0, "R7");
    step(1, 0, 0, 0, "R8");
    step(0, 1, 0, 0, "R7");
    step(1, 0, 1, 0, "R7");
    step(0, 0, 0, 0, "R2");
    step(1, 0, 0, 0, "R4");

    // R10: hold entry, priority and release
    step(0, 0, 0, 1, "R10");
    step(0, 0, 1, 1, "R10");
    step(0, 0, 1, 0, "R10");
    step(0, 0, 0, 1, "R10");
    step(0, 1, 1, 1, "R10");
    step(1, 0, 1, 1, "R10");
    step(0, 0, 0, 0, "R10");
    step(0, 0, 0, 0, "R10");

    // random mix; requests held until acknowledged (R11 address tracking)
    q_on = 0;
    for (int i = 0; i < 4000; i++) begin
      bit q;
      q = q_on ? 1'b1 : ($urandom_range(0, 3) != 0);
      step($urandom_range(0, 2) == 0, $urandom_range(0, 1) == 0, q,
           $urandom_range(0, 9) == 0, "R11");
      q_on = q && !last_ack;
    end

    fin = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule